// File: doc/BRIEF.md
# Adaptive Noise Immunity Level Controller

This block holds the five receiver-sensitivity knobs of a wireless baseband: a noise immunity level, a spur immunity level, a first-step level, an OFDM weak-signal detector enable and a CCK weak-signal detector enable. For each knob it produces the register field values the receive chain needs. These are AGC target and coarse thresholds, a cyclic-power threshold, a first-step field, a block of OFDM weak-signal correlation thresholds and a CCK weak-signal threshold.

A calibration engine sends single-cycle requests. It sends a raise request when too many PHY timing errors were seen, and a flag tells whether OFDM errors caused it. It sends a lower request when errors were rare. Each step moves the knobs along a fixed priority order. The order differs between raising and lowering, and it depends on the averaged beacon RSSI band, on access-point versus station operation and on the band. A mode select applies fixed presets. Requests are acted on only in the automatic mode. A done pulse, one cycle after a request, carries a mask of the knobs that actually changed.

Top module: `ani_level_ctrl`

## Requirements
- R1: After reset the noise, spur and first-step levels are 0, OFDM weak-signal detection is on, CCK weak-signal detection is off, step_done is 0 and the active mode is automatic.
- R2: Noise level 0 drives desired-size -55, coarse-low -64, coarse-high -14 and FIR power -78. Level 1 drives -62, -70, -12 and -80. All four are 8-bit two's complement.
- R3: The cyclic-power field is 2*(spur+1). The first-step field is 4*level. The CCK threshold is 6 when its detector is on and 8 when it is off. The OFDM weak fields (m1 low, m2 low, m1 high, m2 high, m2 count, m2 low count) are 50, 40, 77, 64, 16, 48 when on and 127, 127, 127, 127, 31, 63 when off.
- R4: A raise first sets noise from 0 to 1. Failing that, on an OFDM trigger, it increments spur if spur is below max_spur_cfg. Failing that, in access-point mode, it increments first-step if below 2, and otherwise changes nothing.
- R5: In station mode with beacon_rssi > RSSI_HI_THR, a raise not handled by R4 does one of two things. On an OFDM trigger with OFDM weak detection on, it turns that detection off and sets spur to 0. Otherwise it increments first-step if below 2.
- R6: In station mode with RSSI_LO_THR < beacon_rssi <= RSSI_HI_THR, a raise not handled by R4 turns OFDM weak detection on if the trigger is OFDM and detection was off. In the same step it also increments first-step if below 2.
- R7: In station mode with beacon_rssi <= RSSI_LO_THR, a raise not handled by R4 acts only on the 2.4 GHz band. There it turns OFDM weak detection off on an OFDM trigger and sets first-step to 0. On the other band it changes nothing.
- R8: A lower step changes at most one knob. In access-point mode it first decrements first-step. In station mode the first action depends on RSSI. Mid RSSI first turns OFDM weak detection on and then decrements first-step. Low RSSI only decrements first-step. High RSSI does neither. If none of these applies, it decrements spur, and if that is 0 as well, it clears noise.
- R9: The mode is encoded on mode_sel as 0 off, 1 manual low, 2 manual high and 3 automatic. One edge after mode_sel differs from the active mode, the preset is loaded. Off keeps the knobs. Manual low gives all levels 0 with both detectors on. Manual high gives noise 1, spur max_spur_cfg and first-step 2 with both detectors off. Automatic gives all levels 0 with OFDM on and CCK off.
- R10: Requests are ignored and the knobs hold unless automatic is both active and selected. When raise and lower arrive together, the raise is performed.
- R11: One edge after an accepted request, step_done is 1 for one cycle. step_mask flags each knob that changed: bit 0 noise, bit 1 spur, bit 2 first-step, bit 3 OFDM weak, bit 4 CCK weak. A zero mask means no knob moved. step_done is 0 after a preset load or an ignored request, and first-step never exceeds 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Requested mode (0 off, 1 manual low, 2 manual high, 3 automatic) |
| max_spur_cfg | input | 3 | Highest spur level the silicon supports |
| beacon_rssi | input | RSSI_W | Averaged beacon RSSI, unsigned |
| ap_mode | input | 1 | 1 in access-point operation, 0 in station operation |
| band_2g | input | 1 | 1 when operating on the 2.4 GHz band |
| raise_req | input | 1 | Single-cycle request to raise immunity |
| raise_ofdm | input | 1 | The raise was caused by OFDM errors |
| lower_req | input | 1 | Single-cycle request to lower immunity |
| noise_lvl | output | 1 | Noise immunity level |
| spur_lvl | output | 3 | Spur immunity level |
| fstep_lvl | output | 2 | First-step level |
| ofdm_weak_on | output | 1 | OFDM weak-signal detection enabled |
| cck_weak_on | output | 1 | CCK weak-signal detection enabled |
| desired_size_fld | output | 8 | AGC desired-size total field |
| coarse_lo_fld | output | 8 | AGC coarse low field |
| coarse_hi_fld | output | 8 | AGC coarse high field |
| fir_pwr_fld | output | 8 | FIR power field |
| cyc_pwr_fld | output | 5 | Cyclic-power threshold field |
| fstep_fld | output | 4 | First-step field |
| weak_m1_lo_fld | output | 7 | OFDM weak m1 low threshold |
| weak_m2_lo_fld | output | 7 | OFDM weak m2 low threshold |
| weak_m1_hi_fld | output | 7 | OFDM weak m1 high threshold |
| weak_m2_hi_fld | output | 7 | OFDM weak m2 high threshold |
| weak_m2_cnt_fld | output | 5 | OFDM weak m2 count |
| weak_m2_lo_cnt_fld | output | 6 | OFDM weak m2 low count |
| cck_thr_fld | output | 4 | CCK weak-signal threshold |
| step_done | output | 1 | Pulse one edge after an accepted request |
| step_mask | output | 5 | Knobs changed by that step |

## Verification
On every cycle the assertions enforce several properties. The knobs hold still when no request is pending or automatic mode is not active. A done pulse appears only after a request. The noise bit of the mask agrees with the actual noise change. A lower step moves at most one knob, and first-step stays in range. The choice of which knob a step moves depends on the RSSI band, the operating mode, the band and the trigger type, and so does the simultaneous weak-signal and first-step change in the mid band. Only the bench's reference model can show those choices, together with the presets and the field encodings. The bench drives random walks through all of them, with RSSI placed on and beside both thresholds.

// File: rtl/ani_pkg.sv
package ani_pkg;

   // knob widths
   localparam int SPUR_W   = 3;
   localparam int FSTEP_W  = 2;
   localparam int FST_SHL  = 2;                 // first-step field = level << 2
   localparam int CYC_W    = SPUR_W + 2;        // holds 2*(max+1)
   localparam int FSF_W    = FSTEP_W + FST_SHL;
   localparam int AGC_W    = 8;
   localparam int WTH_W    = 7;
   localparam int CCK_W    = 4;

   // done mask bit positions
   localparam int MASK_W   = 5;
   localparam int MB_NOISE = 0;
   localparam int MB_SPUR  = 1;
   localparam int MB_FSTEP = 2;
   localparam int MB_OFDM  = 3;
   localparam int MB_CCK   = 4;

   typedef enum logic [1:0] {
      MODE_OFF      = 2'd0,
      MODE_MAN_LOW  = 2'd1,
      MODE_MAN_HIGH = 2'd2,
      MODE_AUTO     = 2'd3
   } ani_mode_e;

   typedef enum logic [1:0] {
      RSSI_LOW  = 2'd0,
      RSSI_MID  = 2'd1,
      RSSI_HIGH = 2'd2
   } rssi_band_e;

   typedef struct packed {
      logic               noise;
      logic [SPUR_W-1:0]  spur;
      logic [FSTEP_W-1:0] fstep;
      logic               ofdm_weak;
      logic               cck_weak;
   } ani_set_t;

   typedef struct packed {
      logic [AGC_W-1:0] dsz;
      logic [AGC_W-1:0] clo;
      logic [AGC_W-1:0] chi;
      logic [AGC_W-1:0] fpw;
      logic [CYC_W-1:0] cyc;
      logic [FSF_W-1:0] fst;
      logic [WTH_W-1:0] m1l;
      logic [WTH_W-1:0] m2l;
      logic [WTH_W-1:0] m1h;
      logic [WTH_W-1:0] m2h;
      logic [4:0]       m2c;
      logic [5:0]       m2lc;
      logic [CCK_W-1:0] cck;
   } ani_fld_t;

endpackage

// File: rtl/ani_step_raise.sv
module ani_step_raise import ani_pkg::*; #(
   parameter int FSTEP_MAX = 2
) (
   input  ani_set_t          cur,
   input  rssi_band_e        rband,
   input  logic              is_ofdm,
   input  logic              ap_mode,
   input  logic              band_2g,
   input  logic [SPUR_W-1:0] spur_max,
   output ani_set_t          nxt
);
   localparam logic [FSTEP_W-1:0] FMAX = FSTEP_W'(FSTEP_MAX);

   always_comb begin
      nxt = cur;
      if (!cur.noise) begin
         nxt.noise = 1'b1;
      end else if (is_ofdm && (cur.spur < spur_max)) begin
         nxt.spur = cur.spur + 1'b1;
      end else if (ap_mode) begin
         if (cur.fstep < FMAX) nxt.fstep = cur.fstep + 1'b1;
      end else begin
         case (rband)
            RSSI_HIGH: begin
               if (is_ofdm && cur.ofdm_weak) begin
                  nxt.ofdm_weak = 1'b0;
                  nxt.spur      = '0;
               end else if (cur.fstep < FMAX) begin
                  nxt.fstep = cur.fstep + 1'b1;
               end
            end
            RSSI_MID: begin
               if (is_ofdm && !cur.ofdm_weak) nxt.ofdm_weak = 1'b1;
               if (cur.fstep < FMAX) nxt.fstep = cur.fstep + 1'b1;
            end
            default: begin
               if (band_2g) begin
                  if (is_ofdm) nxt.ofdm_weak = 1'b0;
                  nxt.fstep = '0;
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/ani_step_lower.sv
module ani_step_lower import ani_pkg::*; (
   input  ani_set_t   cur,
   input  rssi_band_e rband,
   input  logic       ap_mode,
   output ani_set_t   nxt
);
   logic taken;

   always_comb begin
      nxt   = cur;
      taken = 1'b0;
      if (ap_mode) begin
         if (cur.fstep != '0) begin
            nxt.fstep = cur.fstep - 1'b1;
            taken     = 1'b1;
         end
      end else begin
         case (rband)
            RSSI_HIGH: taken = 1'b0;
            RSSI_MID: begin
               if (!cur.ofdm_weak) begin
                  nxt.ofdm_weak = 1'b1;
                  taken         = 1'b1;
               end else if (cur.fstep != '0) begin
                  nxt.fstep = cur.fstep - 1'b1;
                  taken     = 1'b1;
               end
            end
            default: begin
               if (cur.fstep != '0) begin
                  nxt.fstep = cur.fstep - 1'b1;
                  taken     = 1'b1;
               end
            end
         endcase
      end
      if (!taken) begin
         if (cur.spur != '0)  nxt.spur  = cur.spur - 1'b1;
         else if (cur.noise)  nxt.noise = 1'b0;
      end
   end

endmodule

// File: rtl/ani_field_map.sv
module ani_field_map import ani_pkg::*; (
   input  ani_set_t s,
   output ani_fld_t f
);
   logic [SPUR_W:0] spur_p1;

   always_comb begin
      spur_p1 = {1'b0, s.spur} + 1'b1;
      f = '0;
      // noise immunity: two-entry table, two's complement
      if (s.noise) begin
         f.dsz = 8'hC2;  f.clo = 8'hBA;  f.chi = 8'hF4;  f.fpw = 8'hB0;
      end else begin
         f.dsz = 8'hC9;  f.clo = 8'hC0;  f.chi = 8'hF2;  f.fpw = 8'hB2;
      end
      f.cyc = {spur_p1, 1'b0};
      f.fst = {s.fstep, {FST_SHL{1'b0}}};
      if (s.ofdm_weak) begin
         f.m1l = 7'd50;  f.m2l = 7'd40;  f.m1h = 7'd77;  f.m2h = 7'd64;
         f.m2c = 5'd16;  f.m2lc = 6'd48;
      end else begin
         f.m1l = 7'd127; f.m2l = 7'd127; f.m1h = 7'd127; f.m2h = 7'd127;
         f.m2c = 5'd31;  f.m2lc = 6'd63;
      end
      f.cck = s.cck_weak ? 4'd6 : 4'd8;
   end

endmodule

// File: rtl/ani_level_ctrl.sv
module ani_level_ctrl import ani_pkg::*; #(
   parameter int RSSI_W      = 8,
   parameter int RSSI_HI_THR = 40,
   parameter int RSSI_LO_THR = 7,
   parameter int FSTEP_MAX   = 2,
   parameter bit FIELD_REG   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          mode_sel,
   input  logic [SPUR_W-1:0]   max_spur_cfg,
   input  logic [RSSI_W-1:0]   beacon_rssi,
   input  logic                ap_mode,
   input  logic                band_2g,
   input  logic                raise_req,
   input  logic                raise_ofdm,
   input  logic                lower_req,
   output logic                noise_lvl,
   output logic [SPUR_W-1:0]   spur_lvl,
   output logic [FSTEP_W-1:0]  fstep_lvl,
   output logic                ofdm_weak_on,
   output logic                cck_weak_on,
   output logic [AGC_W-1:0]    desired_size_fld,
   output logic [AGC_W-1:0]    coarse_lo_fld,
   output logic [AGC_W-1:0]    coarse_hi_fld,
   output logic [AGC_W-1:0]    fir_pwr_fld,
   output logic [CYC_W-1:0]    cyc_pwr_fld,
   output logic [FSF_W-1:0]    fstep_fld,
   output logic [WTH_W-1:0]    weak_m1_lo_fld,
   output logic [WTH_W-1:0]    weak_m2_lo_fld,
   output logic [WTH_W-1:0]    weak_m1_hi_fld,
   output logic [WTH_W-1:0]    weak_m2_hi_fld,
   output logic [4:0]          weak_m2_cnt_fld,
   output logic [5:0]          weak_m2_lo_cnt_fld,
   output logic [CCK_W-1:0]    cck_thr_fld,
   output logic                step_done,
   output logic [MASK_W-1:0]   step_mask
);
   localparam logic [RSSI_W-1:0]  HI_V = RSSI_W'(RSSI_HI_THR);
   localparam logic [RSSI_W-1:0]  LO_V = RSSI_W'(RSSI_LO_THR);
   localparam logic [FSTEP_W-1:0] FMAX = FSTEP_W'(FSTEP_MAX);
   localparam ani_set_t RESET_SET = '{noise: 1'b0, spur: '0, fstep: '0,
                                      ofdm_weak: 1'b1, cck_weak: 1'b0};

   // elaboration-time parameter checks
   if (RSSI_LO_THR >= RSSI_HI_THR) begin : g_bad_thr
      $error("low RSSI threshold must be below the high one");
   end
   if (RSSI_HI_THR >= (1 << RSSI_W)) begin : g_bad_hi
      $error("high RSSI threshold does not fit RSSI_W");
   end
   if (FSTEP_MAX < 1 || FSTEP_MAX >= (1 << FSTEP_W)) begin : g_bad_fstep
      $error("FSTEP_MAX out of range for FSTEP_W");
   end

   ani_mode_e  act_mode, mode_in;
   rssi_band_e rband;
   ani_set_t   cur_q, raise_nxt, lower_nxt, step_nxt, preset, nxt;
   logic       mode_chg, step_en;
   logic [MASK_W-1:0] diff;

   assign mode_in  = ani_mode_e'(mode_sel);
   assign mode_chg = (mode_in != act_mode);
   assign step_en  = !mode_chg && (act_mode == MODE_AUTO) && (raise_req || lower_req);

   always_comb begin
      if (beacon_rssi > HI_V)      rband = RSSI_HIGH;
      else if (beacon_rssi > LO_V) rband = RSSI_MID;
      else                         rband = RSSI_LOW;
   end

   ani_step_raise #(.FSTEP_MAX(FSTEP_MAX)) u_raise (
      .cur      (cur_q),
      .rband    (rband),
      .is_ofdm  (raise_ofdm),
      .ap_mode  (ap_mode),
      .band_2g  (band_2g),
      .spur_max (max_spur_cfg),
      .nxt      (raise_nxt)
   );

   ani_step_lower u_lower (
      .cur     (cur_q),
      .rband   (rband),
      .ap_mode (ap_mode),
      .nxt     (lower_nxt)
   );

   // presets per mode
   always_comb begin
      case (mode_in)
         MODE_MAN_LOW:  preset = '{noise: 1'b0, spur: '0, fstep: '0,
                                   ofdm_weak: 1'b1, cck_weak: 1'b1};
         MODE_MAN_HIGH: preset = '{noise: 1'b1, spur: max_spur_cfg, fstep: FMAX,
                                   ofdm_weak: 1'b0, cck_weak: 1'b0};
         MODE_AUTO:     preset = RESET_SET;
         default:       preset = cur_q;
      endcase
   end

   assign step_nxt = raise_req ? raise_nxt : lower_nxt;

   always_comb begin
      if (mode_chg)     nxt = preset;
      else if (step_en) nxt = step_nxt;
      else              nxt = cur_q;
   end

   assign diff[MB_NOISE] = step_nxt.noise     != cur_q.noise;
   assign diff[MB_SPUR]  = step_nxt.spur      != cur_q.spur;
   assign diff[MB_FSTEP] = step_nxt.fstep     != cur_q.fstep;
   assign diff[MB_OFDM]  = step_nxt.ofdm_weak != cur_q.ofdm_weak;
   assign diff[MB_CCK]   = step_nxt.cck_weak  != cur_q.cck_weak;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q     <= RESET_SET;
         act_mode  <= MODE_AUTO;
         step_done <= 1'b0;
         step_mask <= '0;
      end else begin
         cur_q     <= nxt;
         act_mode  <= mode_in;
         step_done <= step_en;
         step_mask <= step_en ? diff : '0;
      end
   end

   // field generation: registered from next state, or decoded from state
   ani_fld_t fld_out;

   if (FIELD_REG) begin : g_fld_reg
      ani_fld_t fld_c, fld_rst, fld_q;
      ani_field_map u_fmap     (.s(nxt),       .f(fld_c));
      ani_field_map u_fmap_rst (.s(RESET_SET), .f(fld_rst));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) fld_q <= fld_rst;
         else        fld_q <= fld_c;
      end
      assign fld_out = fld_q;
   end else begin : g_fld_comb
      ani_field_map u_fmap (.s(cur_q), .f(fld_out));
   end

   assign noise_lvl          = cur_q.noise;
   assign spur_lvl           = cur_q.spur;
   assign fstep_lvl          = cur_q.fstep;
   assign ofdm_weak_on       = cur_q.ofdm_weak;
   assign cck_weak_on        = cur_q.cck_weak;
   assign desired_size_fld   = fld_out.dsz;
   assign coarse_lo_fld      = fld_out.clo;
   assign coarse_hi_fld      = fld_out.chi;
   assign fir_pwr_fld        = fld_out.fpw;
   assign cyc_pwr_fld        = fld_out.cyc;
   assign fstep_fld          = fld_out.fst;
   assign weak_m1_lo_fld     = fld_out.m1l;
   assign weak_m2_lo_fld     = fld_out.m2l;
   assign weak_m1_hi_fld     = fld_out.m1h;
   assign weak_m2_hi_fld     = fld_out.m2h;
   assign weak_m2_cnt_fld    = fld_out.m2c;
   assign weak_m2_lo_cnt_fld = fld_out.m2lc;
   assign cck_thr_fld        = fld_out.cck;

   // assertions
   AST_FSTEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      fstep_lvl <= FMAX) else $error("first-step above maximum"); // R11

   AST_HOLD_NOT_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_chg && act_mode != MODE_AUTO) |=> ($stable(cur_q) && !step_done))
      else $error("knobs moved outside automatic mode"); // R10

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_chg && !raise_req && !lower_req) |=> $stable(cur_q))
      else $error("knobs moved without a request"); // R10

   AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      step_done |-> $past(raise_req || lower_req))
      else $error("done without request"); // R11

   AST_MASK_NOISE: assert property (@(posedge clk) disable iff (!rst_n)
      step_done |-> (step_mask[MB_NOISE] == (noise_lvl != $past(noise_lvl))))
      else $error("noise mask bit disagrees with noise change"); // R11

   AST_LOWER_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (step_done && $past(lower_req && !raise_req)) |-> ($countones(step_mask) <= 1))
      else $error("lower step moved more than one knob"); // R8

endmodule

// File: tb/ani_level_ctrl_tb.sv
`timescale 1ns/1ps
module ani_level_ctrl_tb;
   localparam int HI = 40;
   localparam int LO = 7;

   typedef struct {
      int noise;
      int spur;
      int fstep;
      int ow;
      int cw;
   } mset_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode_sel = 2'd3;
   logic [2:0] max_spur_cfg = 3'd7;
   logic [7:0] beacon_rssi = 8'd0;
   logic       ap_mode = 1'b0, band_2g = 1'b0;
   logic       raise_req = 1'b0, raise_ofdm = 1'b0, lower_req = 1'b0;

   logic       noise_lvl, ofdm_weak_on, cck_weak_on, step_done;
   logic [2:0] spur_lvl;
   logic [1:0] fstep_lvl;
   logic [7:0] dsz, clo, chi, fpw;
   logic [4:0] cyc, m2c;
   logic [3:0] fst, cck;
   logic [6:0] m1l, m2l, m1h, m2h;
   logic [5:0] m2lc;
   logic [4:0] step_mask;

   always #4 clk = ~clk;   // 125 MHz

   ani_level_ctrl #(.RSSI_HI_THR(HI), .RSSI_LO_THR(LO)) u_dut (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .max_spur_cfg(max_spur_cfg),
      .beacon_rssi(beacon_rssi), .ap_mode(ap_mode), .band_2g(band_2g),
      .raise_req(raise_req), .raise_ofdm(raise_ofdm), .lower_req(lower_req),
      .noise_lvl(noise_lvl), .spur_lvl(spur_lvl), .fstep_lvl(fstep_lvl),
      .ofdm_weak_on(ofdm_weak_on), .cck_weak_on(cck_weak_on),
      .desired_size_fld(dsz), .coarse_lo_fld(clo), .coarse_hi_fld(chi), .fir_pwr_fld(fpw),
      .cyc_pwr_fld(cyc), .fstep_fld(fst),
      .weak_m1_lo_fld(m1l), .weak_m2_lo_fld(m2l), .weak_m1_hi_fld(m1h), .weak_m2_hi_fld(m2h),
      .weak_m2_cnt_fld(m2c), .weak_m2_lo_cnt_fld(m2lc), .cck_thr_fld(cck),
      .step_done(step_done), .step_mask(step_mask)
   );

   int    n_chk = 0, n_fail = 0;
   bit    finished = 1'b0;
   mset_t mcur;
   int    mmode;

   task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [63:0] pack_set(input mset_t s);
      return {57'd0, s.noise[0], s.spur[2:0], s.fstep[1:0], s.ow[0], s.cw[0]};
   endfunction

   // R2 expected noise fields
   function automatic logic [63:0] exp_noise_f(input mset_t s);
      if (s.noise != 0) return {32'd0, 8'(-62), 8'(-70), 8'(-12), 8'(-80)};
      return {32'd0, 8'(-55), 8'(-64), 8'(-14), 8'(-78)};
   endfunction

   // R3 expected remaining fields
   function automatic logic [63:0] exp_other_f(input mset_t s);
      logic [4:0] c; logic [3:0] f, k; logic [27:0] w; logic [10:0] cnt;
      c = 5'(2 * (s.spur + 1));
      f = 4'(4 * s.fstep);
      k = (s.cw != 0) ? 4'd6 : 4'd8;
      if (s.ow != 0) begin w = {7'd50, 7'd40, 7'd77, 7'd64};     cnt = {5'd16, 6'd48}; end
      else           begin w = {7'd127, 7'd127, 7'd127, 7'd127}; cnt = {5'd31, 6'd63}; end
      return {12'd0, c, f, k, w, cnt};
   endfunction

   function automatic mset_t m_preset(input int m, input mset_t c, input int smax);
      mset_t n = c;
      case (m)
         1: begin n.noise = 0; n.spur = 0; n.fstep = 0; n.ow = 1; n.cw = 1; end
         2: begin n.noise = 1; n.spur = smax; n.fstep = 2; n.ow = 0; n.cw = 0; end
         3: begin n.noise = 0; n.spur = 0; n.fstep = 0; n.ow = 1; n.cw = 0; end
         default: ;
      endcase
      return n;
   endfunction

   function automatic mset_t m_raise(input mset_t c, input bit o, input bit ap, input bit b2,
                                     input int r, input int smax, output string tag);
      mset_t n = c;
      tag = "R4";
      if (c.noise < 1) n.noise = 1;
      else if (o && c.spur < smax) n.spur = c.spur + 1;
      else if (ap) begin if (c.fstep < 2) n.fstep = c.fstep + 1; end
      else if (r > HI) begin
         tag = "R5";
         if (o && c.ow != 0) begin n.ow = 0; n.spur = 0; end
         else if (c.fstep < 2) n.fstep = c.fstep + 1;
      end else if (r > LO) begin
         tag = "R6";
         if (o && c.ow == 0) n.ow = 1;
         if (c.fstep < 2) n.fstep = c.fstep + 1;
      end else begin
         tag = "R7";
         if (b2) begin if (o) n.ow = 0; n.fstep = 0; end
      end
      return n;
   endfunction

   function automatic mset_t m_lower(input mset_t c, input bit ap, input int r);
      mset_t n = c;
      bit t = 0;
      if (ap) begin if (c.fstep > 0) begin n.fstep = c.fstep - 1; t = 1; end end
      else if (r > HI) t = 0;
      else if (r > LO) begin
         if (c.ow == 0) begin n.ow = 1; t = 1; end
         else if (c.fstep > 0) begin n.fstep = c.fstep - 1; t = 1; end
      end else if (c.fstep > 0) begin n.fstep = c.fstep - 1; t = 1; end
      if (!t) begin
         if (c.spur > 0) n.spur = c.spur - 1;
         else if (c.noise > 0) n.noise = 0;
      end
      return n;
   endfunction

   // drive one cycle of stimulus (called right after a negedge), then check
   task automatic apply(input int m, input int smax, input int r, input bit ap, input bit b2,
                        input bit rq, input bit ro, input bit lq);
      mset_t n; string tag; logic [4:0] emask; bit edone;
      mode_sel = 2'(m); max_spur_cfg = 3'(smax); beacon_rssi = 8'(r);
      ap_mode = ap; band_2g = b2; raise_req = rq; raise_ofdm = ro; lower_req = lq;
      edone = 0; emask = '0;
      if (m != mmode) begin n = m_preset(m, mcur, smax); tag = "R9"; mmode = m; end
      else if (mmode == 3 && (rq || lq)) begin
         if (rq) n = m_raise(mcur, ro, ap, b2, r, smax, tag);
         else begin n = m_lower(mcur, ap, r); tag = "R8"; end
         edone = 1;
         emask = {n.cw != mcur.cw, n.ow != mcur.ow, n.fstep != mcur.fstep,
                  n.spur != mcur.spur, n.noise != mcur.noise};
      end else begin n = mcur; tag = "R10"; end
      @(posedge clk);
      @(negedge clk);
      raise_req = 1'b0; lower_req = 1'b0;
      chk(tag, "knobs", pack_set('{noise_lvl, spur_lvl, fstep_lvl, ofdm_weak_on, cck_weak_on}), pack_set(n));
      chk("R11", "done/mask", {58'd0, step_done, step_mask}, {58'd0, edone, emask});
      chk("R2", "noise fields", {32'd0, dsz, clo, chi, fpw}, exp_noise_f(n));
      chk("R3", "other fields", {12'd0, cyc, fst, cck, m1l, m2l, m1h, m2h, m2c, m2lc}, exp_other_f(n));
      mcur = n;
   endtask

   initial begin
      #(200000 * 8);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL R11 watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'd7031);
      mcur  = '{noise: 0, spur: 0, fstep: 0, ow: 1, cw: 0};
      mmode = 3;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "reset knobs", pack_set('{noise_lvl, spur_lvl, fstep_lvl, ofdm_weak_on, cck_weak_on}), pack_set(mcur));
      chk("R1", "reset done", {58'd0, step_done, step_mask}, 64'd0);
      chk("R1", "reset fields", {32'd0, dsz, clo, chi, fpw}, exp_noise_f(mcur));

      // R9 presets
      apply(2, 2, 0, 0, 0, 0, 0, 0);
      apply(0, 5, 0, 0, 0, 0, 0, 0);
      apply(0, 5, 0, 0, 0, 1, 1, 0);      // R10 ignored in off
      apply(1, 5, 0, 0, 0, 0, 0, 0);
      apply(1, 5, 0, 0, 0, 0, 0, 1);      // R10 ignored in manual
      apply(3, 2, 0, 0, 0, 1, 0, 0);      // load auto, request dropped
      // R4 raise order
      apply(3, 2, 20, 0, 0, 1, 0, 0);
      apply(3, 2, 20, 0, 0, 1, 1, 0);
      apply(3, 2, 20, 0, 0, 1, 1, 0);
      // R5 high RSSI: OFDM weak off and spur zeroed, then first-step
      apply(3, 2, HI + 1, 0, 0, 1, 1, 0);
      apply(3, 0, HI + 1, 0, 0, 1, 0, 0);
      // R6 mid RSSI at the upper edge: weak on + first-step together
      apply(3, 0, HI, 0, 0, 1, 1, 0);
      // R7 low RSSI, 5 GHz no change, then 2.4 GHz
      apply(3, 0, LO, 0, 0, 1, 1, 0);
      apply(3, 0, LO, 0, 1, 1, 1, 0);
      // AP raise to max
      apply(3, 0, 0, 1, 0, 1, 0, 0);
      apply(3, 0, 0, 1, 0, 1, 0, 0);
      apply(3, 0, 0, 1, 0, 1, 0, 0);
      // R8 lowering walk, both requests (R10 raise wins)
      apply(3, 0, HI + 1, 0, 0, 0, 0, 1);
      apply(3, 0, LO + 1, 0, 0, 0, 0, 1);
      apply(3, 0, 0, 1, 0, 1, 0, 1);
      for (int i = 0; i < 6; i++) apply(3, 0, 0, 1, 0, 0, 0, 1);

      // constrained random walk
      for (int i = 0; i < 4000; i++) begin
         int m, sm, r, sel;
         bit rq, lq;
         m  = mmode;
         sm = int'(max_spur_cfg);
         if ($urandom_range(39) == 0) begin
            m  = ($urandom_range(1) == 1) ? 3 : int'($urandom_range(3));
            sm = ($urandom_range(1) == 1) ? 7 : 2;
         end
         sel = int'($urandom_range(5));
         case (sel)
            0: r = HI;
            1: r = HI + 1;
            2: r = LO;
            3: r = LO + 1;
            default: r = int'($urandom_range(255));
         endcase
         rq = ($urandom_range(2) == 0);
         lq = ($urandom_range(2) == 0);
         apply(m, sm, r, bit'($urandom_range(1)), bit'($urandom_range(1)),
               rq, bit'($urandom_range(1)), lq);
      end

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule